// File: doc/BRIEF.md
# Chainable TDM Serial Output Port

This block is the serial output stage of an audio device that can be chained with identical devices onto one time-division-multiplexed data line. A stereo sample pair (left and right, `SAMPLE_W` bits each) is handed in over a valid/ready stream and held in a single holding slot. When a frame-sync pulse is seen, the whole pair is parallel-loaded into a 64-bit shift register. The register is then shifted out, MSB first, on the bit clock. At the same time its low end fills with bits from the previous device in the chain. When the serial output of one device feeds the chain input of the next, N devices form one long shift register. That register carries one N×64-bit TDM frame.

The port runs in one of two clock roles, chosen by a plain input. As clock master it divides the system clock into a bit clock and makes a frame-sync pulse for a fixed four-device (256-bit) frame. As clock slave it takes both clocks from outside, passes them straight to its clock outputs, and follows their edges. In slave mode the frame length is set only by how far apart the external frame-sync pulses are. All logic runs on the system clock. External clocks and the chain input are synchronised and edge-detected.

Stream rules: `s_ready` is high whenever the holding slot is empty. A pair is taken on any system clock edge where `s_valid` and `s_ready` are both high. The slot is freed by the next frame load. While the slot is full, `s_ready` stays low and the producer must hold its pair. If no new pair arrives before a load, the last pair taken is sent again.

Top module: `tdm_chain_tx`

## Requirements
- R1: After reset `sdata_o` is 0 and `s_ready` is 1. Before the first frame load the port shifts out only zeros while the chain input is 0.
- R2: The loaded word holds the left sample in bits 63:32 and the right sample in bits 31:0. Each sample is left-justified in its 32-bit half, with the low bits zero-padded. Bit 63 is sent first.
- R3: When frame sync is high at a rising bit-clock edge, the next falling edge loads the held pair. The load replaces the whole register. The chain-input bit taken at that rising edge is dropped: load wins over shift.
- R4: On every other falling bit-clock edge the register shifts one place toward its MSB, and `sdata_o` shows the MSB. The chain-input bit sampled at the preceding rising edge enters the LSB, so each chain bit leaves `sdata_o` 64 bit periods later.
- R5: `s_ready` is high exactly when the holding slot is empty. A handshake fills the slot and drops `s_ready`. A frame load empties the slot and raises `s_ready` again.
- R6: If no pair is accepted between two loads, the second load sends the same pair again. Without a handshake the held pair never changes.
- R7: In master mode (`master_en`=1), `bclk_o` has a period of 2×`HALF_DIV` system clocks. A frame is `CHAIN_DEV`×64 bit periods. `fs_o` is high for exactly one bit period, the last one of each frame, and rises together with a falling edge of `bclk_o`.
- R8: In slave mode (`master_en`=0), `bclk_o` equals `ext_bclk` and `fs_o` equals `ext_fs`. Loading and shifting follow the external edges, for any spacing of the frame-sync pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state is clocked here |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 = generate bit clock and frame sync, 0 = follow external clocks |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_fs | input | 1 | External frame-sync pulse (slave mode) |
| tdm_in | input | 1 | Serial data from the previous device in the chain |
| s_valid | input | 1 | Sample pair on `s_left`/`s_right` is valid |
| s_ready | output | 1 | Holding slot empty, pair will be taken |
| s_left | input | SAMPLE_W | Left sample |
| s_right | input | SAMPLE_W | Right sample |
| bclk_o | output | 1 | Bit clock out (generated or passed through) |
| fs_o | output | 1 | Frame sync out (generated or passed through) |
| sdata_o | output | 1 | Serial data out, MSB of the shift register |

## Verification
In master mode the load is driven with sample pairs that separate the ways the output can go wrong. A lone set MSB and LSB in each sample show the justification and padding. All-ones shows the zero padding. Alternating patterns show swapped halves, and an all-zero left with edge bits set on the right shows bleed between the halves. Each frame also drives a distinct 64-bit chain-input pattern (mixed, all zeros, all ones, end bits only). Its reappearance 64 bits later proves the cascade path and the exact bit delay. Between frames the chain input idles at 1, so a load that failed to replace the register, or took the pending chain bit, would show stray ones. A frame with no new pair checks the repeat-on-underrun rule. A slave-mode run with a 128-bit external frame checks clock pass-through and that frame length comes only from the external pulses.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;
  localparam int SLOT_W = 32;
  localparam int WORD_W = 2 * SLOT_W;

  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } clk_role_e;
endpackage

// File: rtl/tdm_clk_unit.sv
module tdm_clk_unit
  import tdm_chain_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int FRAME_BITS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en,
  input  logic ext_bclk,
  input  logic ext_fs,
  input  logic tdm_in,
  output logic rise_stb,
  output logic fall_stb,
  output logic fs_int,
  output logic din_int,
  output logic bclk_o,
  output logic fs_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int IDX_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  clk_role_e role;
  assign role = clk_role_e'(master_en);

  // master-side bit clock and frame counter
  logic [DIV_W-1:0] div_cnt;
  logic [IDX_W-1:0] bit_idx;
  logic             gen_bclk;
  logic             gen_fs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      gen_bclk <= 1'b1;
      bit_idx  <= '0;
    end else if (role == ROLE_MASTER) begin
      if (div_cnt == DIV_LAST) begin
        div_cnt  <= '0;
        gen_bclk <= ~gen_bclk;
        if (gen_bclk) begin
          bit_idx <= (bit_idx == IDX_LAST) ? '0 : bit_idx + 1'b1;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign gen_fs = (bit_idx == IDX_LAST);

  // slave-side synchronisers, chain input always synchronised
  logic [1:0] bclk_sy;
  logic [1:0] fs_sy;
  logic [1:0] din_sy;
  logic       bclk_prev;
  logic       bclk_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_sy <= 2'b11;
      fs_sy   <= 2'b00;
      din_sy  <= 2'b00;
    end else begin
      bclk_sy <= {bclk_sy[0], ext_bclk};
      fs_sy   <= {fs_sy[0], ext_fs};
      din_sy  <= {din_sy[0], tdm_in};
    end
  end

  assign bclk_int = (role == ROLE_MASTER) ? gen_bclk : bclk_sy[1];
  assign fs_int   = (role == ROLE_MASTER) ? gen_fs   : fs_sy[1];
  assign din_int  = din_sy[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev <= 1'b1;
    else        bclk_prev <= bclk_int;
  end

  assign rise_stb = bclk_int & ~bclk_prev;
  assign fall_stb = ~bclk_int & bclk_prev;

  assign bclk_o = (role == ROLE_MASTER) ? gen_bclk : ext_bclk;
  assign fs_o   = (role == ROLE_MASTER) ? gen_fs   : ext_fs;

  // R7: generated frame sync starts together with a falling bit clock
  p_fs_at_fall_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && $rose(gen_fs)) |-> $fell(gen_bclk));
endmodule

// File: rtl/tdm_pair_hold.sv
module tdm_pair_hold
  import tdm_chain_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  input  logic                load,
  output logic [WORD_W-1:0]   word_o
);
  localparam int PAD_W = SLOT_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] left_q;
  logic [SAMPLE_W-1:0] right_q;
  logic                full;
  logic                accept;

  assign s_ready = ~full;
  assign accept  = s_valid & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
      full    <= 1'b0;
    end else begin
      if (accept) begin
        left_q  <= s_left;
        right_q <= s_right;
        full    <= 1'b1;
      end else if (load) begin
        full <= 1'b0;
      end
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign word_o = {left_q, {PAD_W{1'b0}}, right_q, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign word_o = {left_q, right_q};
    end
  endgenerate

  // R5: a handshake closes the slot on the next cycle
  p_ready_blocks_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);
  // R5: a load of a full slot reopens it
  p_slot_free_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (load && !s_ready) |=> s_ready);
  // R6: without a handshake the held pair stays as it was
  p_hold_keep_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=> $stable(word_o));
endmodule

// File: rtl/tdm_frame_shifter.sv
module tdm_frame_shifter
  import tdm_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              fs_in,
  input  logic              ser_in,
  input  logic [WORD_W-1:0] par_word,
  output logic              ser_out,
  output logic              load_stb
);
  logic [WORD_W-1:0] sr;
  logic              fs_seen;
  logic              bit_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      fs_seen <= 1'b0;
      bit_cap <= 1'b0;
    end else begin
      if (rise_stb) begin
        fs_seen <= fs_in;
        bit_cap <= ser_in;
      end
      if (fall_stb) begin
        if (fs_seen) sr <= par_word;
        else         sr <= {sr[WORD_W-2:0], bit_cap};
      end
    end
  end

  assign load_stb = fall_stb & fs_seen;
  assign ser_out  = sr[WORD_W-1];

  // R3: after a load the output shows the MSB of the loaded word
  p_load_msb_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && fs_seen) |=> (ser_out == $past(par_word[WORD_W-1])));
  // R4: the output moves only on a falling bit-clock edge
  p_out_on_fall_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    !fall_stb |=> $stable(ser_out));
endmodule

// File: rtl/tdm_chain_tx.sv
module tdm_chain_tx
  import tdm_chain_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int CHAIN_DEV = 4,
  parameter int HALF_DIV  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                master_en,
  input  logic                ext_bclk,
  input  logic                ext_fs,
  input  logic                tdm_in,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                bclk_o,
  output logic                fs_o,
  output logic                sdata_o
);
  localparam int FRAME_BITS = CHAIN_DEV * WORD_W;

  logic              rise_stb;
  logic              fall_stb;
  logic              fs_int;
  logic              din_int;
  logic              load_stb;
  logic [WORD_W-1:0] held_word;

  tdm_clk_unit #(
    .HALF_DIV  (HALF_DIV),
    .FRAME_BITS(FRAME_BITS)
  ) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .master_en(master_en),
    .ext_bclk (ext_bclk),
    .ext_fs   (ext_fs),
    .tdm_in   (tdm_in),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .fs_int   (fs_int),
    .din_int  (din_int),
    .bclk_o   (bclk_o),
    .fs_o     (fs_o)
  );

  tdm_pair_hold #(
    .SAMPLE_W(SAMPLE_W)
  ) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(s_valid),
    .s_ready(s_ready),
    .s_left (s_left),
    .s_right(s_right),
    .load   (load_stb),
    .word_o (held_word)
  );

  tdm_frame_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_stb(rise_stb),
    .fall_stb(fall_stb),
    .fs_in   (fs_int),
    .ser_in  (din_int),
    .par_word(held_word),
    .ser_out (sdata_o),
    .load_stb(load_stb)
  );
endmodule

// File: tb/sim_tdm_chain_tx.sv
module sim_tdm_chain_tx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int SH         = 6;
  localparam int WD_CYCLES  = 150000;

  localparam logic [23:0] V_L [4] = '{24'h800001, 24'hFFFFFF, 24'hA5A5A5, 24'h000000};
  localparam logic [23:0] V_R [4] = '{24'h000001, 24'hFFFFFF, 24'h5A5A5A, 24'hC00003};
  localparam logic [63:0] V_W [4] = '{64'h80000100_00000100, 64'hFFFFFF00_FFFFFF00,
                                      64'hA5A5A500_5A5A5A00, 64'h00000000_C0000300};
  localparam logic [63:0] V_P [4] = '{64'hDEADBEEF_01234567, 64'h0,
                                      64'hFFFFFFFF_FFFFFFFF, 64'h80000000_00000001};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_en = 1'b1;
  logic        ext_bclk = 1'b1;
  logic        ext_fs = 1'b0;
  logic        tdm_in = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_left = '0;
  logic [23:0] s_right = '0;
  logic        bclk_o;
  logic        fs_o;
  logic        sdata_o;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  bit          bcur = 1'b1;
  bit          bprev = 1'b1;
  bit          mstr = 1'b1;
  logic [63:0] din_pat = '0;
  int          din_left = 0;
  bit          din_idle = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_chain_tx #(.SAMPLE_W(24), .CHAIN_DEV(4), .HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .ext_bclk(ext_bclk),
    .ext_fs(ext_fs), .tdm_in(tdm_in), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .bclk_o(bclk_o), .fs_o(fs_o),
    .sdata_o(sdata_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    bprev = bcur;
    bcur  = bclk_o;
    if (mstr && bprev && !bcur) begin
      if (din_left > 0) begin
        tdm_in   = din_pat[63];
        din_pat  = din_pat << 1;
        din_left = din_left - 1;
      end else begin
        tdm_in = din_idle;
      end
    end
  endtask

  task automatic next_rise(output bit d, output bit f);
    do step(); while (!(bcur && !bprev));
    d = sdata_o;
    f = fs_o;
  endtask

  task automatic push(input logic [23:0] l, input logic [23:0] r);
    while (!s_ready) step();
    s_valid = 1'b1;
    s_left  = l;
    s_right = r;
    step();
    s_valid = 1'b0;
  endtask

  task automatic do_reset(input bit m);
    rst_n     = 1'b0;
    master_en = m;
    mstr      = m;
    ext_bclk  = 1'b1;
    ext_fs    = 1'b0;
    tdm_in    = 1'b0;
    din_left  = 0;
    din_idle  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bcur  = 1'b1;
    bprev = 1'b1;
  endtask

  // waits for the frame-sync bit, then collects 128 output bits
  task automatic cap_frame(input logic [63:0] pat, output logic [63:0] w,
                           output logic [63:0] tl, output int fs_hits);
    bit d, f;
    do next_rise(d, f); while (!f);
    din_pat  = pat;
    din_left = 64;
    fs_hits  = 0;
    w  = '0;
    tl = '0;
    for (int k = 0; k < 128; k++) begin
      next_rise(d, f);
      if (k < 64) w[63-k] = d;
      else        tl[127-k] = d;
      if (f) fs_hits++;
    end
  endtask

  task automatic s_bit(input bit fsv, input bit din, output bit d, inout int bad);
    @(negedge clk);
    ext_bclk = 1'b0;
    ext_fs   = fsv;
    tdm_in   = din;
    repeat (SH) @(negedge clk);
    d = sdata_o;
    if (bclk_o !== ext_bclk || fs_o !== ext_fs) bad++;
    ext_bclk = 1'b1;
    repeat (SH) @(negedge clk);
    if (bclk_o !== 1'b1 || fs_o !== ext_fs) bad++;
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] w, tl;
    int          hits, zeros_bad, cnt, pt_bad;
    bit          d, f;
    time         t0, t1;

    // ---------------- master mode ----------------
    do_reset(1'b1);
    chk(sdata_o == 1'b0, "R1 reset sdata_o", 64'(sdata_o), 64'd0);
    chk(s_ready == 1'b1, "R1 reset s_ready", 64'(s_ready), 64'd1);
    chk(fs_o == 1'b0 && bclk_o == 1'b1, "R7 reset clocks idle",
        64'({fs_o, bclk_o}), 64'b01);

    push(V_L[0], V_R[0]);
    chk(s_ready == 1'b0, "R5 slot full after handshake", 64'(s_ready), 64'd0);

    // R1: zeros before the first frame sync
    zeros_bad = 0;
    cnt = 0;
    do begin
      next_rise(d, f);
      if (!f && d) zeros_bad++;
      cnt++;
    end while (!f);
    chk(zeros_bad == 0, "R1 zeros before first load", 64'(zeros_bad), 64'd0);

    // from here the chain input idles at 1 between patterns (R3 replace check)
    din_idle = 1'b1;

    // vector table walk: frame already armed for entry 0
    for (int i = 0; i < 4; i++) begin
      if (i == 0) begin
        din_pat  = V_P[0];
        din_left = 64;
        w = '0;
        tl = '0;
        hits = 0;
        for (int k = 0; k < 128; k++) begin
          next_rise(d, f);
          if (k < 64) w[63-k] = d;
          else        tl[127-k] = d;
          if (f) hits++;
        end
      end else begin
        cap_frame(V_P[i], w, tl, hits);
      end
      chk(w == V_W[i], "R2 R3 loaded word", w, V_W[i]);
      chk(tl == V_P[i], "R4 chain bits after 64", tl, V_P[i]);
      chk(hits == 0, "R7 no frame sync mid-frame", 64'(hits), 64'd0);
      chk(s_ready == 1'b1, "R5 slot freed by load", 64'(s_ready), 64'd1);
      if (i < 3) push(V_L[i+1], V_R[i+1]);
    end

    // R6: no new pair, next frame repeats the last one
    cap_frame(64'h01234567_89ABCDEF, w, tl, hits);
    chk(w == V_W[3], "R6 repeat on underrun", w, V_W[3]);
    chk(tl == 64'h01234567_89ABCDEF, "R4 chain bits second pattern", tl,
        64'h01234567_89ABCDEF);

    // R7: frame length: rises from bit 128 up to and including next sync
    cnt = 0;
    do begin
      next_rise(d, f);
      cnt++;
    end while (!f);
    chk(cnt == 128, "R7 frame length 256 bits", 64'(cnt), 64'd128);

    // R7: frame sync lasts exactly one bit
    next_rise(d, f);
    chk(f == 1'b0, "R7 frame sync one bit wide", 64'(f), 64'd0);

    // R7: bit clock period
    next_rise(d, f);
    t0 = $time;
    next_rise(d, f);
    t1 = $time;
    chk((t1 - t0) == 2 * HALF * CLK_PERIOD, "R7 bit clock period",
        64'(t1 - t0), 64'(2 * HALF * CLK_PERIOD));

    // ---------------- slave mode, 128-bit external frame ----------------
    do_reset(1'b0);
    chk(bclk_o == ext_bclk && fs_o == ext_fs, "R8 pass-through after reset",
        64'({bclk_o, fs_o}), 64'({ext_bclk, ext_fs}));
    push(24'h13579B, 24'h2468AC);
    pt_bad = 0;
    zeros_bad = 0;
    for (int k = 0; k < 128; k++) begin
      s_bit(k == 127, 1'b0, d, pt_bad);
      if (d) zeros_bad++;
    end
    chk(zeros_bad == 0, "R1 slave zeros before first load", 64'(zeros_bad), 64'd0);
    w = '0;
    tl = '0;
    for (int k = 0; k < 128; k++) begin
      s_bit(k == 127, (k < 64) ? V_P[0][63-k] : 1'b1, d, pt_bad);
      if (k < 64) w[63-k] = d;
      else        tl[127-k] = d;
    end
    chk(w == 64'h13579B00_2468AC00, "R8 R2 slave loaded word", w,
        64'h13579B00_2468AC00);
    chk(tl == V_P[0], "R8 R4 slave chain bits", tl, V_P[0]);
    chk(pt_bad == 0, "R8 clock pass-through", 64'(pt_bad), 64'd0);
    chk(s_ready == 1'b1, "R5 slave slot freed", 64'(s_ready), 64'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule